// File: doc/BRIEF.md
# Timed Digital Line Bank with Waveform FIFO

This block drives a bank of general-purpose digital lines. Software chooses, line by line, whether a line is an input, a static output that holds a value set from the register interface, or a waveform output that follows samples played from a FIFO. The host or a memory-transfer engine fills that FIFO through a write port.

Waveform playback has no dedicated clock. The update pace comes from a sample clock that is taken from an external pin or from one of several internal timing signals. Software also picks whether the rising or the falling edge of that clock is active. Using the same source as other sampled subsystems keeps digital updates aligned in time with them. The chosen source is synchronized into the system clock domain and edge-detected. Each active edge pops one FIFO entry into the waveform register. If an edge arrives while the FIFO is empty, the block raises a sticky underflow flag and the lines hold their value. Two designated lines are also tapped, input only, as up/down controls for external counters.

Top module: `wavedio_port`

## Requirements
- R1: After reset every line is an input (all `pin_oe` low, `pin_out` zero), and the status word at address 3 reads 1: bit0 empty=1, bit1 full=0, bit2 underflow=0, bit3 overflow=0.
- R2: Address 0 holds a 2-bit mode per line, with line i at bits [2i+1:2i]. Code 0 and code 3 make the line an input (oe low, out 0). Code 1 makes the line drive the static data bit. Code 2 makes the line drive the waveform register bit.
- R3: The static data register (low NLINES bits at address 1) changes only when address 1 is written. Reading address 1 returns the present `pin_in` value, zero-extended.
- R4: Samples leave the FIFO in the order they were written, exactly one per active sample-clock edge.
- R5: Bit 2 of address 2 selects the active edge: 0 for rising, 1 for falling. An edge of the opposite polarity pops nothing.
- R6: Bits [1:0] of address 2 select the sample clock: 0 is `ext_sclk`, k is `int_sclk[k-1]`. Edges on unselected sources have no effect.
- R7: An active edge while the FIFO is empty sets the underflow flag (status bit2) and leaves the lines unchanged. The flag stays set until address 3 is written with bit0=1.
- R8: A FIFO write while full is discarded and sets the overflow flag (status bit3). The flag is cleared by writing address 3 with bit1=1.
- R9: `cnt_updn[0]` follows `pin_in[6]` and `cnt_updn[1]` follows `pin_in[7]`, and the values on these lines do not alter `pin_oe` or `pin_out`.
- R10: `fifo_full` is asserted after FIFO_DEPTH unread writes, and `fifo_empty` is asserted when no sample is held. The two are never high together.
- R11: If a host write and an active edge land in the same cycle on an empty FIFO, the edge counts as an underflow and the written sample is kept for the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 data, 2 control, 3 status) |
| reg_wdata | input | 2*NLINES | Register write data |
| reg_rdata | output | 2*NLINES | Register read data for `reg_addr` |
| fifo_wr | input | 1 | Waveform sample write strobe |
| fifo_wdata | input | NLINES | Waveform sample |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH samples |
| fifo_empty | output | 1 | FIFO holds no sample |
| ext_sclk | input | 1 | External sample clock (asynchronous) |
| int_sclk | input | NINT_SRC | Shared internal sample clocks |
| pin_in | input | NLINES | Sensed line levels |
| pin_out | output | NLINES | Driven line levels |
| pin_oe | output | NLINES | Per-line output enable |
| cnt_updn | output | 2 | Up/down taps for counters 0 and 1 |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
A sample-clock pop and a host FIFO write can fall in the same system cycle, and so can a write and a full FIFO. The bench times the raw clock change so that the synchronized strobe is high exactly in the cycle where it raises `fifo_wr` on an empty FIFO. It then expects underflow set, the FIFO no longer empty, and that sample on the lines after the next edge. For the full case, a seventeenth write must leave the drained sequence unchanged and set overflow.

// File: rtl/wdio_pkg.sv
package wdio_pkg;
    typedef enum logic [1:0] {
        LM_INPUT  = 2'd0,
        LM_STATIC = 2'd1,
        LM_WAVE   = 2'd2,
        LM_SPARE  = 2'd3
    } line_mode_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/wdio_fifo.sv
module wdio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push_ok)
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end
endmodule

// File: rtl/wdio_sclk_strobe.sv
module wdio_sclk_strobe #(
    parameter int NINT = 3,
    parameter int SYNC = 2,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_sclk,
    input  logic [NINT-1:0] int_sclk,
    input  logic [SELW-1:0] sel,
    input  logic            fall_edge,
    output logic            strobe
);
    localparam int NSRC = NINT + 1;

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [NSRC-1:0] srcs;
    logic raw, lvl;

    assign srcs = {int_sclk, ext_sclk};
    assign raw  = (int'(sel) < NSRC) ? srcs[sel] : 1'b0;
    assign lvl  = st_q.sync[SYNC-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], raw};
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = fall_edge ? (!lvl && st_q.prev) : (lvl && !st_q.prev);
endmodule

// File: rtl/wavedio_port.sv
module wavedio_port #(
    parameter int NLINES      = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int NINT_SRC    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int UPDN_LINE0  = 6,
    parameter int UPDN_LINE1  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [2*NLINES-1:0]   reg_wdata,
    output logic [2*NLINES-1:0]   reg_rdata,
    input  logic                  fifo_wr,
    input  logic [NLINES-1:0]     fifo_wdata,
    output logic                  fifo_full,
    output logic                  fifo_empty,
    input  logic                  ext_sclk,
    input  logic [NINT_SRC-1:0]   int_sclk,
    input  logic [NLINES-1:0]     pin_in,
    output logic [NLINES-1:0]     pin_out,
    output logic [NLINES-1:0]     pin_oe,
    output logic [1:0]            cnt_updn,
    output logic                  underflow,
    output logic                  overflow
);
    import wdio_pkg::*;

    localparam int NSRC = NINT_SRC + 1;
    localparam int SELW = (NSRC > 2) ? $clog2(NSRC) : 1;
    localparam int RW   = 2 * NLINES;

    typedef struct packed {
        logic [RW-1:0]     mode;
        logic [NLINES-1:0] sdata;
        logic [NLINES-1:0] wave;
        logic [SELW-1:0]   sel;
        logic              fall;
        logic              unf;
        logic              ovf;
    } port_st_t;

    port_st_t st_d, st_q;
    logic pop_stb;
    logic [NLINES-1:0] fifo_head;

    wdio_sclk_strobe #(
        .NINT (NINT_SRC),
        .SYNC (SYNC_STAGES),
        .SELW (SELW)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sclk  (ext_sclk),
        .int_sclk  (int_sclk),
        .sel       (st_q.sel),
        .fall_edge (st_q.fall),
        .strobe    (pop_stb)
    );

    wdio_fifo #(
        .W     (NLINES),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_wr),
        .push_data (fifo_wdata),
        .pop       (pop_stb),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_MODE: st_d.mode  = reg_wdata;
                ADDR_DATA: st_d.sdata = reg_wdata[NLINES-1:0];
                ADDR_CTRL: begin
                    st_d.sel  = reg_wdata[SELW-1:0];
                    st_d.fall = reg_wdata[SELW];
                end
                default: begin
                    if (reg_wdata[0]) st_d.unf = 1'b0;
                    if (reg_wdata[1]) st_d.ovf = 1'b0;
                end
            endcase
        end
        if (pop_stb) begin
            if (fifo_empty) st_d.unf  = 1'b1;
            else            st_d.wave = fifo_head;
        end
        if (fifo_wr && fifo_full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_MODE: reg_rdata = st_q.mode;
            ADDR_DATA: reg_rdata = RW'(pin_in);
            ADDR_CTRL: reg_rdata = RW'({st_q.fall, st_q.sel});
            default:   reg_rdata = RW'({st_q.ovf, st_q.unf, fifo_full, fifo_empty});
        endcase
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_mode_e lm;
        assign lm         = line_mode_e'(st_q.mode[2*i +: 2]);
        assign pin_oe[i]  = (lm == LM_STATIC) || (lm == LM_WAVE);
        assign pin_out[i] = (lm == LM_WAVE)   ? st_q.wave[i]  :
                            (lm == LM_STATIC) ? st_q.sdata[i] : 1'b0;
    end

    assign cnt_updn  = {pin_in[UPDN_LINE1], pin_in[UPDN_LINE0]};
    assign underflow = st_q.unf;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/wavedio_port_chk.sv
module wavedio_port_chk #(
    parameter int NLINES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [2*NLINES-1:0] reg_wdata,
    input logic              fifo_wr,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              pop_stb,
    input logic [NLINES-1:0] pin_out,
    input logic [NLINES-1:0] pin_oe,
    input logic              underflow,
    input logic              overflow
);
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb |=> !pop_stb);

    assert_underflow_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb && fifo_empty |=> underflow);

    assert_hold_on_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb && fifo_empty && !reg_wr |=> $stable(pin_out));

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0]) |=> underflow);

    assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr && fifo_full |=> overflow);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_write_during_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr && fifo_empty && pop_stb |=> !fifo_empty && underflow);
endmodule

bind wavedio_port wavedio_port_chk #(.NLINES(NLINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .fifo_wr    (fifo_wr),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .pop_stb    (pop_stb),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .underflow  (underflow),
    .overflow   (overflow)
);

// File: tb/wavedio_port_tb.sv
`timescale 1ns/1ps
module wavedio_port_tb;
    localparam int N = 8;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [2*N-1:0] reg_wdata = '0;
    logic [2*N-1:0] reg_rdata;
    logic fifo_wr = 1'b0;
    logic [N-1:0] fifo_wdata = '0;
    logic fifo_full, fifo_empty;
    logic ext_sclk = 1'b0;
    logic [2:0] int_sclk = '0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic [1:0] cnt_updn;
    logic underflow, overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wavedio_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .ext_sclk(ext_sclk), .int_sclk(int_sclk),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .cnt_updn(cnt_updn),
        .underflow(underflow), .overflow(overflow)
    );

    // {mode[15:0], static[7:0], sample[7:0], expected out[7:0], expected oe[7:0]}
    localparam logic [47:0] VEC [5] = '{
        {16'h5555, 8'hA5, 8'h3C, 8'hA5, 8'hFF},
        {16'hAAAA, 8'h00, 8'h96, 8'h96, 8'hFF},
        {16'h0000, 8'hFF, 8'h11, 8'h00, 8'h00},
        {16'hC5AA, 8'hFF, 8'hF3, 8'h33, 8'h3F},
        {16'hAAAA, 8'hFF, 8'h00, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [2*N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [2*N-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [N-1:0] d);
        @(negedge clk);
        fifo_wr = 1'b1; fifo_wdata = d;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic v);
        if (idx == 0) ext_sclk = v;
        else          int_sclk[idx-1] = v;
    endtask

    task automatic pulse_src(input int idx);
        @(negedge clk);
        set_src(idx, 1'b1);
        repeat (6) @(negedge clk);
        set_src(idx, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", 32'(pin_oe), 32'h00);
        check("R1 out", 32'(pin_out), 32'h00);
        reg_read(2'd3, rd);
        check("R1 status", 32'(rd), 32'h1);

        // R2 vector table, one rising ext edge per entry
        for (int i = 0; i < 5; i++) begin
            reg_write(2'd0, VEC[i][47:32]);
            reg_write(2'd1, {8'h00, VEC[i][31:24]});
            push(VEC[i][23:16]);
            pulse_src(0);
            check("R2 out", 32'(pin_out), 32'(VEC[i][15:8]));
            check("R2 oe", 32'(pin_oe), 32'(VEC[i][7:0]));
        end

        // R3 static data only from register writes; read returns pins
        reg_write(2'd0, 16'h5555);
        reg_write(2'd1, 16'h005A);
        pin_in = 8'hC3;
        repeat (2) @(negedge clk);
        check("R3 static out", 32'(pin_out), 32'h5A);
        reg_read(2'd1, rd);
        check("R3 pin read", 32'(rd), 32'h00C3);
        pin_in = 8'h00;

        // R4 order of playback
        reg_write(2'd0, 16'hAAAA);
        push(8'h01); push(8'h02); push(8'h03);
        check("R4 before edge", 32'(pin_out), 32'h00);
        pulse_src(0); check("R4 first", 32'(pin_out), 32'h01);
        pulse_src(0); check("R4 second", 32'(pin_out), 32'h02);
        pulse_src(0); check("R4 third", 32'(pin_out), 32'h03);

        // R5 falling-edge polarity
        reg_write(2'd2, 16'h0004);
        push(8'h77);
        @(negedge clk); ext_sclk = 1'b1;
        repeat (6) @(negedge clk);
        check("R5 rise ignored", 32'(pin_out), 32'h03);
        ext_sclk = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 fall pops", 32'(pin_out), 32'h77);
        reg_write(2'd2, 16'h0000);

        // R6 source selection
        reg_write(2'd2, 16'h0001);
        push(8'h44);
        pulse_src(0);
        check("R6 ext ignored", 32'(pin_out), 32'h77);
        check("R6 fifo kept", 32'(fifo_empty), 32'h0);
        pulse_src(1);
        check("R6 int0 pops", 32'(pin_out), 32'h44);
        reg_write(2'd2, 16'h0000);

        // R7 underflow
        pulse_src(0);
        reg_read(2'd3, rd);
        check("R7 underflow set", 32'(rd[2]), 32'h1);
        check("R7 lines hold", 32'(pin_out), 32'h44);
        repeat (3) @(negedge clk);
        check("R7 sticky", 32'(underflow), 32'h1);
        reg_write(2'd3, 16'h0001);
        check("R7 cleared", 32'(underflow), 32'h0);

        // R10 and R8 fill, overflow, drain
        for (int i = 0; i < DEPTH; i++) push(8'(8'h20 + i));
        check("R10 full", 32'(fifo_full), 32'h1);
        push(8'hEE);
        check("R8 overflow", 32'(overflow), 32'h1);
        for (int i = 0; i < DEPTH; i++) pulse_src(0);
        check("R8 drained last", 32'(pin_out), 32'h2F);
        check("R10 empty", 32'(fifo_empty), 32'h1);
        check("R8 no underflow", 32'(underflow), 32'h0);
        reg_write(2'd3, 16'h0002);
        check("R8 cleared", 32'(overflow), 32'h0);

        // R11 write and active edge in the same cycle on an empty FIFO
        @(negedge clk); ext_sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fifo_wr = 1'b1; fifo_wdata = 8'h5C;
        @(negedge clk);
        fifo_wr = 1'b0;
        check("R11 underflow", 32'(underflow), 32'h1);
        check("R11 sample kept", 32'(fifo_empty), 32'h0);
        check("R11 lines hold", 32'(pin_out), 32'h2F);
        repeat (4) @(negedge clk);
        ext_sclk = 1'b0;
        repeat (6) @(negedge clk);
        pulse_src(0);
        check("R11 sample played", 32'(pin_out), 32'h5C);
        reg_write(2'd3, 16'h0001);

        // R9 counter taps
        reg_write(2'd0, 16'h5000);
        reg_write(2'd1, 16'h0080);
        pin_in = 8'h40;
        repeat (2) @(negedge clk);
        check("R9 tap line6", 32'(cnt_updn), 32'h1);
        check("R9 out unchanged", 32'(pin_out), 32'h80);
        check("R9 oe unchanged", 32'(pin_oe), 32'hC0);
        pin_in = 8'h80;
        repeat (2) @(negedge clk);
        check("R9 tap line7", 32'(cnt_updn), 32'h2);
        check("R9 out still", 32'(pin_out), 32'h80);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule